// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Repeat Masks

This block watches a running BCD time (seconds, minutes, hours, day of month) and raises a one-cycle interrupt pulse when the time matches a programmed alarm. The timekeeper that owns the running time is outside this block. It drives the four current-time fields and a one-second tick. The comparison is made only in the tick cycle, so a match gives exactly one pulse.

Each of the four alarm bytes carries a repeat mask in bit 7, which takes that field out of the compare. The masks form a ladder that selects the repeat period. With no mask set the alarm is monthly. Masking the date gives a daily alarm. Masking date and hour gives an hourly alarm. Masking date, hour and minute gives one alarm per minute. Any other combination fires on every tick. Alarm bytes that do not hold a legal BCD value are refused. A separate interrupt-enable byte is stored exactly as written, and its bit 7 gates the pulse.

Top module: `alarm_match`

## Requirements
- R1: A write to the seconds alarm (select 0) or the minutes alarm (select 1) is stored, as the whole byte, only when bits 6:0 are BCD 00..59. The low nibble must be 9 or less. Any other write leaves the register unchanged.
- R2: A write to the hours alarm (select 2) is stored only when bits 5:0 are BCD 00..23. Otherwise the register is unchanged.
- R3: A write to the date alarm (select 3) is stored only when bits 5:0 are BCD 01..31. A zero value is refused.
- R4: With the mask bit (bit 7) clear in all four alarm bytes, a tick fires only when seconds [6:0], minutes [6:0], hours [5:0] and date [5:0] all equal the current time.
- R5: With only the date mask set, a tick fires when seconds, minutes and hours match, whatever the date.
- R6: With the date and hour masks set and the others clear, a tick fires when seconds and minutes match.
- R7: With the date, hour and minute masks set and the seconds mask clear, a tick fires when seconds match.
- R8: Any other mask combination, for example any in which the seconds mask is set, fires on every tick.
- R9: A firing appears as `irq` high for exactly the one cycle after the tick cycle. `irq` never rises without a tick.
- R10: The interrupt-enable byte (select 4) stores every write whole and reads back unchanged. `irq` can fire only while its bit 7 is set.
- R11: After reset, every register reads 0 and `irq` is low. Selects 5..7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1s | input | 1 | One-cycle strobe, once per second |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write select: 0 sec, 1 min, 2 hour, 3 date, 4 enable |
| wr_data | input | 8 | Write data |
| rd_sel | input | 3 | Read select, same encoding |
| rd_data | output | 8 | Read data (combinational) |
| irq | output | 1 | Alarm interrupt pulse |

## Verification
On every cycle, the checker confirms four things. A pulse follows a tick while the enable bit was set. A refused seconds or date write and any write to an unused select leave the stored state untouched. The enable byte takes each write whole. A tick with the seconds mask set always fires. Only the bench's scenarios can show the remaining behaviour. That covers the match conditions for the monthly, daily, hourly and per-minute periods, including a near miss on the field that decides each one. It also covers the mask patterns outside the ladder, the BCD range limits on each field and the release of the pulse.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
   localparam int SEL_SEC  = 0;
   localparam int SEL_MIN  = 1;
   localparam int SEL_HOUR = 2;
   localparam int SEL_DATE = 3;
   localparam int SEL_ENA  = 4;
   localparam int N_FIELDS = 4;

   // bits of each alarm byte that take part in the compare
   function automatic logic [7:0] field_bits(input int idx);
      case (idx)
         SEL_SEC, SEL_MIN: field_bits = 8'h7F;
         default:          field_bits = 8'h3F;
      endcase
   endfunction

   // legal packed BCD whose value lies in [lo, hi]
   function automatic logic bcd_in_range(input logic [7:0] v, input int lo, input int hi);
      int val;
      val = int'(v[7:4]) * 10 + int'(v[3:0]);
      bcd_in_range = (v[3:0] <= 4'd9) && (val >= lo) && (val <= hi);
   endfunction

   function automatic logic field_ok(input int idx, input logic [7:0] v);
      case (idx)
         SEL_SEC, SEL_MIN: field_ok = bcd_in_range(v & 8'h7F, 0, 59);
         SEL_HOUR:         field_ok = bcd_in_range(v & 8'h3F, 0, 23);
         default:          field_ok = bcd_in_range(v & 8'h3F, 1, 31);
      endcase
   endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
   import alarm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [SEL_W-1:0]              wr_sel,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic [SEL_W-1:0]              rd_sel,
   output logic [DATA_W-1:0]             rd_data,
   output logic [N_FIELDS-1:0][DATA_W-1:0] alm_q,
   output logic [DATA_W-1:0]             ena_q
);
   genvar gi;
   generate
      for (gi = 0; gi < N_FIELDS; gi++) begin : g_field
         logic hit_sel;
         assign hit_sel = wr_en && (int'(wr_sel) == gi) && field_ok(gi, wr_data);
         always_ff @(posedge clk) begin
            if (!rst_n)       alm_q[gi] <= '0;
            else if (hit_sel) alm_q[gi] <= wr_data;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                                  ena_q <= '0;
      else if (wr_en && int'(wr_sel) == SEL_ENA)   ena_q <= wr_data;
   end

   always_comb begin
      if (int'(rd_sel) < N_FIELDS)       rd_data = alm_q[rd_sel[1:0]];
      else if (int'(rd_sel) == SEL_ENA)  rd_data = ena_q;
      else                               rd_data = '0;
   end
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
   import alarm_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int MASK_BIT = 7
) (
   input  logic [N_FIELDS-1:0][DATA_W-1:0] alm_q,
   input  logic [N_FIELDS-1:0][DATA_W-1:0] cur,
   output logic                            hit
);
   logic [N_FIELDS-1:0] eq;
   logic [N_FIELDS-1:0] msk;

   genvar gi;
   generate
      for (gi = 0; gi < N_FIELDS; gi++) begin : g_eq
         assign eq[gi]  = ((alm_q[gi] ^ cur[gi]) & field_bits(gi)) == '0;
         assign msk[gi] = alm_q[gi][MASK_BIT];
      end
   endgenerate

   // mask ladder ordered {date, hour, min, sec}
   always_comb begin
      case (msk)
         4'b0000: hit = &eq;
         4'b1000: hit = eq[SEL_HOUR] & eq[SEL_MIN] & eq[SEL_SEC];
         4'b1100: hit = eq[SEL_MIN] & eq[SEL_SEC];
         4'b1110: hit = eq[SEL_SEC];
         default: hit = 1'b1;
      endcase
   end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
   import alarm_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int SEL_W    = 3,
   parameter int MASK_BIT = 7,
   parameter int ENA_BIT  = 7,
   parameter bit REG_IRQ  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1s,
   input  logic [DATA_W-1:0] cur_sec,
   input  logic [DATA_W-1:0] cur_min,
   input  logic [DATA_W-1:0] cur_hour,
   input  logic [DATA_W-1:0] cur_date,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq
);
   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("alarm_match: DATA_W must be 8 for BCD fields");
      end
      if (SEL_W < 3) begin : g_bad_sel
         $error("alarm_match: SEL_W must reach select 4");
      end
      if (MASK_BIT >= DATA_W || ENA_BIT >= DATA_W) begin : g_bad_bit
         $error("alarm_match: bit positions out of range");
      end
   endgenerate

   logic [N_FIELDS-1:0][DATA_W-1:0] alm_q;
   logic [N_FIELDS-1:0][DATA_W-1:0] cur;
   logic [DATA_W-1:0]               ena_q;
   logic                            hit;
   logic                            fire;

   assign cur[SEL_SEC]  = cur_sec;
   assign cur[SEL_MIN]  = cur_min;
   assign cur[SEL_HOUR] = cur_hour;
   assign cur[SEL_DATE] = cur_date;

   alarm_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .alm_q(alm_q), .ena_q(ena_q)
   );

   alarm_cmp #(.DATA_W(DATA_W), .MASK_BIT(MASK_BIT)) u_cmp (
      .alm_q(alm_q), .cur(cur), .hit(hit)
   );

   assign fire = tick_1s & hit & ena_q[ENA_BIT];

   generate
      if (REG_IRQ) begin : g_irq_reg
         always_ff @(posedge clk) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= fire;
         end
      end else begin : g_irq_comb
         assign irq = fire;
      end
   endgenerate
endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk
   import alarm_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int SEL_W    = 3,
   parameter int MASK_BIT = 7,
   parameter int ENA_BIT  = 7,
   parameter bit REG_IRQ  = 1'b1
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            tick_1s,
   input logic                            wr_en,
   input logic [SEL_W-1:0]                wr_sel,
   input logic [DATA_W-1:0]               wr_data,
   input logic [N_FIELDS-1:0][DATA_W-1:0] alm_q,
   input logic [DATA_W-1:0]               ena_q,
   input logic                            irq
);
   // R1
   sec_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_sel) == SEL_SEC && !bcd_in_range(wr_data & 8'h7F, 0, 59))
      |=> $stable(alm_q[SEL_SEC]));

   // R3
   date_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_sel) == SEL_DATE && wr_data[5:0] == 6'd0)
      |=> $stable(alm_q[SEL_DATE]));

   // R10
   ena_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_sel) == SEL_ENA) |=> (ena_q == $past(wr_data)));

   // R11
   unused_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_sel) > SEL_ENA) |=> ($stable(alm_q) && $stable(ena_q)));

   generate
      if (REG_IRQ) begin : g_reg
         // R9
         irq_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> $past(tick_1s));
         // R10
         irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> $past(ena_q[ENA_BIT]));
         // R8
         sec_mask_every_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_1s && ena_q[ENA_BIT] && alm_q[SEL_SEC][MASK_BIT]) |=> irq);
      end else begin : g_comb
         // R9
         irq_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> tick_1s);
         // R10
         irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> ena_q[ENA_BIT]);
         // R8
         sec_mask_every_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_1s && ena_q[ENA_BIT] && alm_q[SEL_SEC][MASK_BIT]) |-> irq);
      end
   endgenerate
endmodule

bind alarm_match alarm_match_chk #(
   .DATA_W(DATA_W), .SEL_W(SEL_W), .MASK_BIT(MASK_BIT),
   .ENA_BIT(ENA_BIT), .REG_IRQ(REG_IRQ)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .wr_en(wr_en),
   .wr_sel(wr_sel), .wr_data(wr_data), .alm_q(alm_q), .ena_q(ena_q),
   .irq(irq)
);

// File: tb/alarm_match_test.sv
module alarm_match_test;
   localparam int CLK_P = 10;
   localparam int NVEC  = 11;
   // {alarm sec, min, hour, date, current sec, min, hour, date, expected}
   localparam logic [71:0] VEC [NVEC] = '{
      72'h12_34_05_15_12_34_05_15_01,   // R4 monthly match
      72'h12_34_05_15_12_34_05_16_00,   // R4 date differs
      72'h12_34_05_95_12_34_05_02_01,   // R5 daily, date ignored
      72'h12_34_05_95_12_34_06_02_00,   // R5 hour differs
      72'h12_34_85_95_12_34_11_02_01,   // R6 hourly
      72'h12_34_85_95_12_35_11_02_00,   // R6 minute differs
      72'h12_B4_85_95_12_00_11_02_01,   // R7 per minute
      72'h12_B4_85_95_13_00_11_02_00,   // R7 second differs
      72'h92_34_05_15_00_00_00_01_01,   // R8 seconds mask only
      72'h92_B4_85_95_00_00_00_01_01,   // R8 all masks
      72'h12_B4_05_95_00_00_00_01_01    // R8 date+minute, hour unmasked
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1s = 1'b0;
   logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_sel = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_sel = '0;
   logic [7:0] rd_data;
   logic       irq;
   int         errors = 0;
   int         checks = 0;

   always #(CLK_P/2) clk = ~clk;

   alarm_match uut (
      .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .cur_sec(cur_sec),
      .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [2:0] sel, input logic [7:0] exp);
      rd_sel = sel;
      #1;
      check(req, rd_data, exp);
   endtask

   // tick in one cycle, irq seen in the next, released after that
   task automatic tick_check(input string req, input logic exp);
      @(negedge clk);
      tick_1s = 1'b1;
      @(negedge clk);
      tick_1s = 1'b0;
      check(req, {7'd0, irq}, {7'd0, exp});
      @(negedge clk);
      check("R9 release", {7'd0, irq}, 8'h00);
   endtask

   initial begin
      #(CLK_P * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state
      check("R11 reset irq", {7'd0, irq}, 8'h00);
      for (int s = 0; s < 8; s++) rd_check("R11 reset read", 3'(s), 8'h00);

      // R10 enable byte
      wr(3'd4, 8'h5C);
      rd_check("R10 store", 3'd4, 8'h5C);
      wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h01);
      cur_sec = 8'h00; cur_min = 8'h00; cur_hour = 8'h00; cur_date = 8'h01;
      tick_check("R10 gate off", 1'b0);
      wr(3'd4, 8'h80);
      rd_check("R10 readback", 3'd4, 8'h80);

      // R9 no tick, no pulse despite match
      repeat (2) @(negedge clk);
      check("R9 no tick", {7'd0, irq}, 8'h00);

      // vector table
      for (int i = 0; i < NVEC; i++) begin
         wr(3'd0, VEC[i][71:64]); wr(3'd1, VEC[i][63:56]);
         wr(3'd2, VEC[i][55:48]); wr(3'd3, VEC[i][47:40]);
         cur_sec = VEC[i][39:32]; cur_min = VEC[i][31:24];
         cur_hour = VEC[i][23:16]; cur_date = VEC[i][15:8];
         tick_check($sformatf("R4-8 vector %0d", i), VEC[i][0]);
      end

      // R1 limits
      wr(3'd0, 8'h59); rd_check("R1 sec 59", 3'd0, 8'h59);
      wr(3'd0, 8'h60); rd_check("R1 sec 60 refused", 3'd0, 8'h59);
      wr(3'd0, 8'h1A); rd_check("R1 sec bad nibble", 3'd0, 8'h59);
      wr(3'd1, 8'hD9); rd_check("R1 min masked 59", 3'd1, 8'hD9);
      wr(3'd1, 8'h7F); rd_check("R1 min refused", 3'd1, 8'hD9);
      // R2 limits
      wr(3'd2, 8'h23); rd_check("R2 hour 23", 3'd2, 8'h23);
      wr(3'd2, 8'h24); rd_check("R2 hour 24 refused", 3'd2, 8'h23);
      // R3 limits
      wr(3'd3, 8'h31); rd_check("R3 date 31", 3'd3, 8'h31);
      wr(3'd3, 8'h00); rd_check("R3 date 0 refused", 3'd3, 8'h31);
      wr(3'd3, 8'h80); rd_check("R3 masked 0 refused", 3'd3, 8'h31);
      wr(3'd3, 8'h32); rd_check("R3 date 32 refused", 3'd3, 8'h31);
      // R11 unused select
      wr(3'd6, 8'hFF);
      rd_check("R11 sel6 read", 3'd6, 8'h00);
      rd_check("R11 enable kept", 3'd4, 8'h80);
      rd_check("R11 sec kept", 3'd0, 8'h59);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule